// File: doc/BRIEF.md
# Slot/Port Network Interrupt Aggregator

This block collects per-port interrupt events from the network modules plugged into a chassis. It keeps them in packed status registers and drives a single network interrupt line toward the processor. Each event carries a slot number and a port number. A set request raises one status bit and a clear request lowers one. The bit position comes from a fixed, deliberately scrambled per-slot base offset plus the port number. Each slot owns four consecutive bits, one per port.

A static chassis-mode input picks one of two layouts. In the four-slot layout every slot lives in one 32-bit main word, and software reads it through four byte windows. In the six-slot layout, slot 0 lives in the low nibble of a separate 8-bit auxiliary register and slots 1 to 6 share the main word. Software reads the main word whole through one window and the auxiliary register through another. Reads are combinational and never change state. The interrupt output is registered and reflects whether any status bit was set on the previous cycle.

Top module: `slot_irq_aggregator`

## Requirements
- R1: After reset every read window returns zero and `net_irq` is low.
- R2: With `chassis_mode` = 0 (four slots), a request for slot s, port p addresses main bit base+p, where base is 16 for slot 0, 24 for slot 1, 0 for slot 2 and 8 for slot 3.
- R3: With `chassis_mode` = 0, `rd_sel` 0 returns main bits 31:24, 1 returns bits 23:16, 2 returns bits 15:8 and 3 returns bits 7:0, each zero-extended in `rd_data`; `rd_sel` 4 to 7 return zero.
- R4: With `chassis_mode` = 1 (six slots), slot 0 port p addresses auxiliary bit p, and slots 1, 2, 3, 4, 5, 6 address main bit base+p with bases 24, 16, 28, 20, 8 and 0.
- R5: With `chassis_mode` = 1, `rd_sel` 0 returns the whole main word, `rd_sel` 1 returns the auxiliary register zero-extended, and `rd_sel` 2 to 7 return zero.
- R6: A set request makes its addressed bit 1, and a clear request makes its addressed bit 0. All other bits keep their values. The change is visible on `rd_data` in the cycle after the request edge.
- R7: When the set and clear ports address the same bit in one cycle, the bit ends up 1.
- R8: A request is ignored if its port number is 4 or more, or if its slot does not exist in the current mode (slot 4 or above in four-slot mode, slot 7 in six-slot mode).
- R9: Bits 7:4 of the auxiliary register, which are reserved for auxiliary-module slots, always read zero.
- R10: `net_irq` is high in the cycle after any main bit is set, or any auxiliary bit is set in six-slot mode. It goes low one cycle after the last such bit clears.
- R11: Reading any window any number of times changes no status bit and does not affect `net_irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chassis_mode | input | 1 | Static layout select: 0 four slots, 1 six slots |
| set_valid | input | 1 | Set request strobe |
| set_slot | input | 3 | Slot of the set request |
| set_port | input | 3 | Port of the set request |
| clr_valid | input | 1 | Clear request strobe |
| clr_slot | input | 3 | Slot of the clear request |
| clr_port | input | 3 | Port of the clear request |
| rd_sel | input | 3 | Read window select |
| rd_data | output | 32 | Contents of the selected window |
| net_irq | output | 1 | Registered network interrupt |

## Verification
The bench walks every slot and port in both layouts. A swapped base offset would therefore light a bit in the wrong byte window, or in the wrong register in six-slot mode. It drives a set and a clear at the same bit in one cycle, and a design that gives clear priority would read back zero there. It sends out-of-range slots and ports, including port numbers that would otherwise land in the reserved auxiliary bits; a decoder without range checks would corrupt a neighbouring slot or a reserved bit. It also samples `net_irq` in the very cycle the status changes and one cycle later. A combinational or two-stage interrupt path would then show up as an early or late edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic {
        MODE_QUAD = 1'b0,
        MODE_HEX  = 1'b1
    } chassis_mode_e;

    typedef struct packed {
        logic       hit;
        logic       to_aux;
        logic [4:0] base;
    } slot_route_t;

    // Slot-to-bit placement; the scrambled order is fixed by software.
    function automatic slot_route_t route_slot(chassis_mode_e mode, logic [2:0] slot);
        slot_route_t r;
        r = '{hit: 1'b0, to_aux: 1'b0, base: 5'd0};
        if (mode == MODE_QUAD) begin
            case (slot)
                3'd0: r = '{hit: 1'b1, to_aux: 1'b0, base: 5'd16};
                3'd1: r = '{hit: 1'b1, to_aux: 1'b0, base: 5'd24};
                3'd2: r = '{hit: 1'b1, to_aux: 1'b0, base: 5'd0};
                3'd3: r = '{hit: 1'b1, to_aux: 1'b0, base: 5'd8};
                default: r.hit = 1'b0;
            endcase
        end else begin
            case (slot)
                3'd0: r = '{hit: 1'b1, to_aux: 1'b1, base: 5'd0};
                3'd1: r = '{hit: 1'b1, to_aux: 1'b0, base: 5'd24};
                3'd2: r = '{hit: 1'b1, to_aux: 1'b0, base: 5'd16};
                3'd3: r = '{hit: 1'b1, to_aux: 1'b0, base: 5'd28};
                3'd4: r = '{hit: 1'b1, to_aux: 1'b0, base: 5'd20};
                3'd5: r = '{hit: 1'b1, to_aux: 1'b0, base: 5'd8};
                3'd6: r = '{hit: 1'b1, to_aux: 1'b0, base: 5'd0};
                default: r.hit = 1'b0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_route_dec.sv
module irq_route_dec
    import irq_agg_pkg::*;
#(
    parameter int MAIN_W = 32,
    parameter int AUX_W  = 8,
    parameter int SLOT_W = 3,
    parameter int PORT_W = 3,
    parameter int PORTS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chassis_mode_e     mode,
    input  logic              req_v,
    input  logic [SLOT_W-1:0] slot,
    input  logic [PORT_W-1:0] port,
    output logic [MAIN_W-1:0] main_mask,
    output logic [AUX_W-1:0]  aux_mask
);
    localparam int IDX_W = $clog2(MAIN_W);
    localparam int AIX_W = $clog2(AUX_W);

    slot_route_t      route;
    logic             port_ok;
    logic [IDX_W-1:0] idx;

    always_comb begin
        route     = route_slot(mode, 3'(slot));
        port_ok   = (port < PORT_W'(PORTS));
        idx       = IDX_W'(route.base) + IDX_W'(port);
        main_mask = '0;
        aux_mask  = '0;
        if (req_v && route.hit && port_ok) begin
            if (route.to_aux) aux_mask[idx[AIX_W-1:0]] = 1'b1;
            else              main_mask[idx]           = 1'b1;
        end
    end

    // R8
    port_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port >= PORT_W'(PORTS)) |-> (main_mask == '0 && aux_mask == '0));

    // R2
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({main_mask, aux_mask}));

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_agg_pkg::*;
#(
    parameter int MAIN_W = 32,
    parameter int AUX_W  = 8,
    parameter int PORTS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chassis_mode_e     mode,
    input  logic [MAIN_W-1:0] set_main,
    input  logic [AUX_W-1:0]  set_aux,
    input  logic [MAIN_W-1:0] clr_main,
    input  logic [AUX_W-1:0]  clr_aux,
    output logic [MAIN_W-1:0] main_q,
    output logic [AUX_W-1:0]  aux_q,
    output logic              irq_q
);
    localparam logic [AUX_W-1:0] AUX_LIVE = AUX_W'((1 << PORTS) - 1);

    typedef struct packed {
        logic [MAIN_W-1:0] main;
        logic [AUX_W-1:0]  aux;
        logic              irq;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.main = (st_q.main & ~clr_main) | set_main;
        st_d.aux  = ((st_q.aux & ~clr_aux) | set_aux) & AUX_LIVE;
        st_d.irq  = (|st_q.main) || (mode == MODE_HEX && (|st_q.aux));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign main_q = st_q.main;
    assign aux_q  = st_q.aux;
    assign irq_q  = st_q.irq;

    // R6
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_main != '0) |=> ((main_q & $past(set_main)) == $past(set_main)));

    // R6
    clr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_main & ~set_main) != '0) |=> ((main_q & $past(clr_main & ~set_main)) == '0));

    // R7
    set_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_aux & clr_aux) != '0) |=> ((aux_q & $past(set_aux)) == $past(set_aux)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_main == '0 && clr_main == '0 && set_aux == '0 && clr_aux == '0)
        |=> ($stable(main_q) && $stable(aux_q)));

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(main_q != '0 || aux_q != '0));

endmodule

// File: rtl/irq_read_win.sv
module irq_read_win
    import irq_agg_pkg::*;
#(
    parameter int MAIN_W = 32,
    parameter int AUX_W  = 8,
    parameter int SEL_W  = 3
) (
    input  chassis_mode_e     mode,
    input  logic [SEL_W-1:0]  sel,
    input  logic [MAIN_W-1:0] main_q,
    input  logic [AUX_W-1:0]  aux_q,
    output logic [MAIN_W-1:0] rd_data
);
    localparam int BYTES = MAIN_W / 8;

    always_comb begin
        rd_data = '0;
        if (mode == MODE_QUAD) begin
            // window k shows byte lane BYTES-1-k (most significant first)
            for (int k = 0; k < BYTES; k++) begin
                if (sel == SEL_W'(k)) rd_data[7:0] = main_q[(BYTES-1-k)*8 +: 8];
            end
        end else begin
            if (sel == SEL_W'(0))      rd_data = main_q;
            else if (sel == SEL_W'(1)) rd_data[AUX_W-1:0] = aux_q;
        end
    end

endmodule

// File: rtl/slot_irq_aggregator.sv
module slot_irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int MAIN_W = 32,
    parameter int AUX_W  = 8,
    parameter int SLOT_W = 3,
    parameter int PORT_W = 3,
    parameter int SEL_W  = 3,
    parameter int PORTS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chassis_mode,
    input  logic              set_valid,
    input  logic [SLOT_W-1:0] set_slot,
    input  logic [PORT_W-1:0] set_port,
    input  logic              clr_valid,
    input  logic [SLOT_W-1:0] clr_slot,
    input  logic [PORT_W-1:0] clr_port,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [MAIN_W-1:0] rd_data,
    output logic              net_irq
);
    localparam int NREQ = 2;   // index 0: set, index 1: clear

    chassis_mode_e     mode;
    logic              req_v    [NREQ];
    logic [SLOT_W-1:0] req_slot [NREQ];
    logic [PORT_W-1:0] req_port [NREQ];
    logic [MAIN_W-1:0] mmask    [NREQ];
    logic [AUX_W-1:0]  amask    [NREQ];
    logic [MAIN_W-1:0] main_q;
    logic [AUX_W-1:0]  aux_q;

    assign mode        = chassis_mode_e'(chassis_mode);
    assign req_v[0]    = set_valid;
    assign req_slot[0] = set_slot;
    assign req_port[0] = set_port;
    assign req_v[1]    = clr_valid;
    assign req_slot[1] = clr_slot;
    assign req_port[1] = clr_port;

    for (genvar r = 0; r < NREQ; r++) begin : g_dec
        irq_route_dec #(
            .MAIN_W(MAIN_W), .AUX_W(AUX_W), .SLOT_W(SLOT_W),
            .PORT_W(PORT_W), .PORTS(PORTS)
        ) u_dec (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (mode),
            .req_v    (req_v[r]),
            .slot     (req_slot[r]),
            .port     (req_port[r]),
            .main_mask(mmask[r]),
            .aux_mask (amask[r])
        );
    end

    irq_status_bank #(.MAIN_W(MAIN_W), .AUX_W(AUX_W), .PORTS(PORTS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .set_main(mmask[0]),
        .set_aux (amask[0]),
        .clr_main(mmask[1]),
        .clr_aux (amask[1]),
        .main_q  (main_q),
        .aux_q   (aux_q),
        .irq_q   (net_irq)
    );

    irq_read_win #(.MAIN_W(MAIN_W), .AUX_W(AUX_W), .SEL_W(SEL_W)) u_win (
        .mode   (mode),
        .sel    (rd_sel),
        .main_q (main_q),
        .aux_q  (aux_q),
        .rd_data(rd_data)
    );

    // R9
    aux_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HEX && rd_sel == SEL_W'(1)) |-> (rd_data[AUX_W-1:PORTS] == '0));

endmodule

// File: tb/tb_slot_irq_aggregator.sv
`timescale 1ns/100ps
module tb_slot_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chassis_mode = 1'b0;
    logic        set_valid = 1'b0, clr_valid = 1'b0;
    logic [2:0]  set_slot = '0, set_port = '0, clr_slot = '0, clr_port = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        net_irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [39:0] exp_st = '0;   // [31:0] main word, [39:32] auxiliary register

    always #2.5 clk = ~clk;

    slot_irq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .chassis_mode(chassis_mode),
        .set_valid(set_valid), .set_slot(set_slot), .set_port(set_port),
        .clr_valid(clr_valid), .clr_slot(clr_slot), .clr_port(clr_port),
        .rd_sel(rd_sel), .rd_data(rd_data), .net_irq(net_irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    function automatic logic [39:0] pos_mask(input bit hex, input int s, input int p);
        int qb[4] = '{16, 24, 0, 8};
        int hb[7] = '{32, 24, 16, 28, 20, 8, 0};
        logic [39:0] m = '0;
        if (p < 0 || p > 3) return m;
        if (!hex && s >= 0 && s < 4) m[qb[s] + p] = 1'b1;
        if (hex && s >= 0 && s < 7) m[hb[s] + p] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] exp_win(input int sel);
        if (!chassis_mode) begin
            case (sel)
                0: return {24'h0, exp_st[31:24]};
                1: return {24'h0, exp_st[23:16]};
                2: return {24'h0, exp_st[15:8]};
                3: return {24'h0, exp_st[7:0]};
                default: return 32'h0;
            endcase
        end
        if (sel == 0) return exp_st[31:0];
        if (sel == 1) return {24'h0, exp_st[39:32]};
        return 32'h0;
    endfunction

    function automatic logic exp_irq();
        return (|exp_st[31:0]) || (chassis_mode && (|exp_st[39:32]));
    endfunction

    task automatic do_reset(input bit hex);
        @(negedge clk);
        rst_n = 1'b0;
        chassis_mode = hex;
        exp_st = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one request cycle; returns at the negedge after the capturing edge.
    task automatic req(input bit sv, input int ss, input int sp,
                       input bit cv, input int cs, input int cp);
        @(negedge clk);
        set_valid = sv; set_slot = 3'(ss); set_port = 3'(sp);
        clr_valid = cv; clr_slot = 3'(cs); clr_port = 3'(cp);
        exp_st = (exp_st & ~(cv ? pos_mask(chassis_mode, cs, cp) : 40'h0))
               | (sv ? pos_mask(chassis_mode, ss, sp) : 40'h0);
        @(negedge clk);
        set_valid = 1'b0; clr_valid = 1'b0;
    endtask

    task automatic read_win(input int sel, output logic [31:0] v);
        rd_sel = 3'(sel);
        #0.5;
        v = rd_data;
    endtask

    task automatic check_windows(input string tag);
        logic [31:0] v;
        for (int s = 0; s < 8; s++) begin
            read_win(s, v);
            check(tag, v, exp_win(s));
        end
    endtask

    task automatic check_irq(input string tag);
        check(tag, {31'h0, net_irq}, {31'h0, exp_irq()});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_windows("R1 windows in reset");
        check("R1 irq in reset", {31'h0, net_irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_windows("R1 windows after reset");
    endtask

    task automatic t_quad_map();
        do_reset(1'b0);
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 4; p++) begin
                req(1, s, p, 0, 0, 0);
                check_windows("R2 four-slot placement");
                @(negedge clk);
                check_irq("R10 irq after set");
                req(0, 0, 0, 1, s, p);
                check_windows("R6 clear back to zero");
            end
        end
    endtask

    task automatic t_quad_windows();
        logic [31:0] v;
        do_reset(1'b0);
        req(1, 1, 0, 0, 0, 0);
        req(1, 0, 1, 0, 0, 0);
        req(1, 3, 2, 0, 0, 0);
        req(1, 2, 3, 0, 0, 0);
        read_win(0, v); check("R3 window0 slot1", v, 32'h01);
        read_win(1, v); check("R3 window1 slot0", v, 32'h02);
        read_win(2, v); check("R3 window2 slot3", v, 32'h04);
        read_win(3, v); check("R3 window3 slot2", v, 32'h08);
        check_windows("R3 all windows");
    endtask

    task automatic t_hex_map();
        logic [31:0] v;
        do_reset(1'b1);
        for (int s = 0; s < 7; s++) begin
            for (int p = 0; p < 4; p++) begin
                req(1, s, p, 0, 0, 0);
                check_windows("R4 six-slot placement");
                req(0, 0, 0, 1, s, p);
            end
        end
        req(1, 0, 2, 0, 0, 0);
        read_win(1, v); check("R4 slot0 to aux bit2", v, 32'h4);
        read_win(0, v); check("R4 slot0 not in main", v, 32'h0);
        req(0, 0, 0, 1, 0, 2);
    endtask

    task automatic t_hex_windows();
        logic [31:0] v;
        do_reset(1'b1);
        req(1, 1, 0, 0, 0, 0);   // bit 24
        req(1, 3, 3, 0, 0, 0);   // bit 31
        req(1, 6, 1, 0, 0, 0);   // bit 1
        req(1, 0, 3, 0, 0, 0);   // aux bit 3
        read_win(0, v); check("R5 main word", v, 32'h8100_0002);
        read_win(1, v); check("R5 aux window", v, 32'h0000_0008);
        check_windows("R5 all windows");
    endtask

    task automatic t_accumulate();
        logic [31:0] v;
        do_reset(1'b0);
        req(1, 0, 0, 0, 0, 0);
        req(1, 0, 3, 0, 0, 0);
        req(1, 2, 1, 0, 0, 0);
        req(0, 0, 0, 1, 0, 0);
        read_win(1, v); check("R6 neighbour kept", v, 32'h08);
        read_win(3, v); check("R6 other slot kept", v, 32'h02);
        req(1, 3, 0, 1, 2, 1);
        check_windows("R6 set and clear distinct bits");
    endtask

    task automatic t_collide();
        logic [31:0] v;
        do_reset(1'b1);
        req(1, 4, 2, 1, 4, 2);
        read_win(0, v); check("R7 set wins main", v, 32'h0040_0000);
        req(1, 0, 1, 1, 0, 1);
        read_win(1, v); check("R7 set wins aux", v, 32'h2);
        do_reset(1'b0);
        req(1, 1, 1, 0, 0, 0);
        req(1, 1, 1, 1, 1, 1);
        read_win(0, v); check("R7 set wins on set bit", v, 32'h02);
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        do_reset(1'b0);
        for (int s = 4; s < 8; s++) req(1, s, 0, 0, 0, 0);
        for (int p = 4; p < 8; p++) req(1, 0, p, 0, 0, 0);
        for (int w = 0; w < 8; w++) begin
            read_win(w, v); check("R8 four-slot bad request", v, 32'h0);
        end
        @(negedge clk);
        check("R8 irq stays low", {31'h0, net_irq}, 32'h0);
        do_reset(1'b1);
        req(1, 7, 0, 0, 0, 0);
        req(1, 3, 5, 0, 0, 0);
        read_win(0, v); check("R8 six-slot bad main", v, 32'h0);
        read_win(1, v); check("R8 six-slot bad aux", v, 32'h0);
        req(1, 2, 0, 0, 0, 0);
        req(0, 0, 0, 1, 7, 0);
        req(0, 0, 0, 1, 2, 6);
        read_win(0, v); check("R8 bad clear ignored", v, 32'h0001_0000);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        do_reset(1'b1);
        for (int p = 0; p < 8; p++) req(1, 0, p, 0, 0, 0);
        read_win(1, v); check("R9 reserved aux bits", v, 32'h0F);
    endtask

    task automatic t_irq_timing();
        do_reset(1'b1);
        @(negedge clk);
        set_valid = 1'b1; set_slot = 3'd0; set_port = 3'd0;
        @(negedge clk);
        set_valid = 1'b0;
        check("R10 irq not yet on capture cycle", {31'h0, net_irq}, 32'h0);
        @(negedge clk);
        check("R10 irq one cycle later", {31'h0, net_irq}, 32'h1);
        @(negedge clk);
        clr_valid = 1'b1; clr_slot = 3'd0; clr_port = 3'd0;
        @(negedge clk);
        clr_valid = 1'b0;
        check("R10 irq held on clear cycle", {31'h0, net_irq}, 32'h1);
        @(negedge clk);
        check("R10 irq drops one cycle later", {31'h0, net_irq}, 32'h0);
        exp_st = '0;
    endtask

    task automatic t_read_clean();
        logic [31:0] a, b;
        do_reset(1'b0);
        req(1, 3, 1, 0, 0, 0);
        for (int k = 0; k < 4; k++) begin
            for (int w = 0; w < 8; w++) read_win(w, a);
            @(negedge clk);
        end
        read_win(2, a);
        read_win(2, b);
        check("R11 repeated read", a, b);
        check_windows("R11 state after reads");
        check_irq("R11 irq after reads");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_quad_map();
        t_quad_windows();
        t_hex_map();
        t_hex_windows();
        t_accumulate();
        t_collide();
        t_ignore();
        t_reserved();
        t_irq_timing();
        t_read_clean();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule